// File: doc/BRIEF.md
# Multi-Port Counting Semaphore With Hardware Wait Queue

This block is one shared counting semaphore for several requesters, such as the ports of a few processor cores. Each port raises a request and says whether it wants to take a token (acquire) or give one back (release). A round-robin arbiter picks at most one request per cycle, so every update to the token count is atomic. An acquire that finds a token takes it and completes at once. An acquire that finds none is parked in a hardware first-in-first-out queue, and its request stays raised.

A release completes at once. If ports are waiting, the token goes straight to the oldest waiter, which is granted in the same cycle, and the count does not change. If nobody is waiting, the count goes up by one. The token count is loaded from `initCount` while reset is held, and that value is also the ceiling: it is the largest number of holders there can be at one time. A release that would push the count past the ceiling is flagged and has no effect on the count.

Top module: `sem_top`

## Requirements
- R1: While `rst_n` is low, the count and the ceiling are loaded from `initCount`, the wait queue is emptied, and the round-robin pointer is set so that port 0 has first priority. After reset, with no requests, `grant` is all zeros and `overflowErr` is 0.
- R2: An acquire (`reqOp` bit = 0) served while the count is above zero pulses that port's `grant` bit in the same cycle and lowers the count by one.
- R3: An acquire served while the count is zero produces no grant. The port is appended to the wait queue, and its held request is not arbitrated again until it is granted.
- R4: A release (`reqOp` bit = 1) served while no port waits grants the releasing port in the same cycle and raises the count by one.
- R5: A release served while ports wait grants the releasing port and the head waiter in the same cycle, and leaves the count unchanged.
- R6: Waiters are granted in the order in which their acquires were served, oldest first.
- R7: At most one request is served per cycle. The port chosen is the first eligible one after the last served port, in increasing index order with wrap-around.
- R8: A release served when the count already equals the ceiling and no port waits still grants the releaser. It pulses `overflowErr` in that cycle, and the count stays at the ceiling.
- R9: The count never goes below zero and never exceeds the ceiling, and ports wait only while the count is zero.
- R10: With a ceiling of zero, every acquire waits until some release hands it a token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads count and ceiling |
| initCount | input | CNT_W | Initial token count and ceiling, sampled during reset |
| reqValid | input | NUM_PORTS | Per-port request, held until that port's grant |
| reqOp | input | NUM_PORTS | Per-port operation: 0 acquire, 1 release |
| grant | output | NUM_PORTS | Per-port one-cycle completion pulse |
| overflowErr | output | 1 | One-cycle pulse on a release beyond the ceiling |

## Verification
A wrong count shows up at the ports within a few requests. A count that is too high grants an acquire that should have waited. A count that is too low parks an acquire that should have been granted, or raises `overflowErr` late or never. Corruption of the wait queue shows up as a handoff grant to the wrong port, or in the wrong order, on the very release that pops it. An arbiter pointer fault shows up as the wrong port winning a cycle with several requests. The bench runs several such multi-request cycles, chained handoffs, a release at the ceiling followed by refills, and a reset with a ceiling of zero.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } semOp_e;

  typedef struct packed {
    logic cntInc;
    logic cntDec;
    logic qPush;
    logic qPop;
  } semStrobe_t;
endpackage

// File: rtl/sem_dpath.sv
module sem_dpath #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     initCount,
  input  sem_pkg::semStrobe_t  strobe,
  input  logic [IDX_W-1:0]     pushIdx,
  output logic                 countZero,
  output logic                 countFull,
  output logic                 queueEmpty,
  output logic [IDX_W-1:0]     headIdx,
  output logic [NUM_PORTS-1:0] waitMask
);
  localparam int OCC_W = IDX_W + 1;

  logic [CNT_W-1:0] count, maxCount;
  logic [IDX_W-1:0] slots [NUM_PORTS];
  logic [IDX_W-1:0] rdPtr, wrPtr;
  logic [OCC_W-1:0] occ;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (int'(p) == NUM_PORTS - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= initCount;
      maxCount <= initCount;
    end else if (strobe.cntInc) begin
      count <= count + 1'b1;
    end else if (strobe.cntDec) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      occ      <= '0;
      waitMask <= '0;
    end else begin
      if (strobe.qPush) begin
        slots[wrPtr]      <= pushIdx;
        wrPtr             <= nextPtr(wrPtr);
        waitMask[pushIdx] <= 1'b1;
      end
      if (strobe.qPop) begin
        rdPtr             <= nextPtr(rdPtr);
        waitMask[headIdx] <= 1'b0;
      end
      case ({strobe.qPush, strobe.qPop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign countZero  = (count == '0);
  assign countFull  = (count == maxCount);
  assign queueEmpty = (occ == '0);
  assign headIdx    = slots[rdPtr];

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= maxCount);
  assert_waiters_imply_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !queueEmpty |-> countZero);
  assert_no_dec_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cntDec |-> !countZero);
  assert_push_only_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.qPush |-> (countZero && !waitMask[pushIdx]));
  assert_handoff_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.qPop |=> $stable(count));
  assert_no_inc_past_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cntInc |-> !countFull);
  assert_occ_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= NUM_PORTS && $countones(waitMask) == int'(occ));
endmodule

// File: rtl/sem_ctrl.sv
module sem_ctrl #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] reqValid,
  input  logic [NUM_PORTS-1:0] reqOp,
  input  logic                 countZero,
  input  logic                 countFull,
  input  logic                 queueEmpty,
  input  logic [IDX_W-1:0]     headIdx,
  input  logic [NUM_PORTS-1:0] waitMask,
  output sem_pkg::semStrobe_t  strobe,
  output logic [IDX_W-1:0]     pushIdx,
  output logic [NUM_PORTS-1:0] grant,
  output logic                 overflowErr
);
  import sem_pkg::*;

  logic [IDX_W-1:0]     lastIdx, selIdx;
  logic                 selValid;
  logic [NUM_PORTS-1:0] eligible;
  semOp_e               selOp;

  assign eligible = reqValid & ~waitMask;

  always_comb begin
    selValid = 1'b0;
    selIdx   = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      int unsigned cand;
      cand = (int'(lastIdx) + k) % NUM_PORTS;
      if (!selValid && eligible[cand]) begin
        selValid = 1'b1;
        selIdx   = IDX_W'(cand);
      end
    end
  end

  assign selOp   = semOp_e'(reqOp[selIdx]);
  assign pushIdx = selIdx;

  always_comb begin
    strobe      = '0;
    grant       = '0;
    overflowErr = 1'b0;
    if (selValid) begin
      if (selOp == OP_ACQ) begin
        if (!countZero) begin
          strobe.cntDec = 1'b1;
          grant[selIdx] = 1'b1;
        end else begin
          strobe.qPush = 1'b1;
        end
      end else begin
        grant[selIdx] = 1'b1;
        if (!queueEmpty) begin
          strobe.qPop    = 1'b1;
          grant[headIdx] = 1'b1;
        end else if (countFull) begin
          overflowErr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lastIdx <= IDX_W'(NUM_PORTS - 1);
    else if (selValid) lastIdx <= selIdx;
  end

  assert_one_op_per_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= 2 && $onehot0(strobe));
  assert_waiter_not_rearbitrated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & waitMask & ~({NUM_PORTS{strobe.qPop}} & (NUM_PORTS'(1) << headIdx))) == '0);
  assert_err_only_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |-> (selValid && reqOp[selIdx] && queueEmpty && countFull));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid == '0) |-> (grant == '0 && !overflowErr));
endmodule

// File: rtl/sem_top.sv
module sem_top #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     initCount,
  input  logic [NUM_PORTS-1:0] reqValid,
  input  logic [NUM_PORTS-1:0] reqOp,
  output logic [NUM_PORTS-1:0] grant,
  output logic                 overflowErr
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  sem_pkg::semStrobe_t  strobe;
  logic [IDX_W-1:0]     pushIdx, headIdx;
  logic                 countZero, countFull, queueEmpty;
  logic [NUM_PORTS-1:0] waitMask;

  sem_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .countZero(countZero), .countFull(countFull), .queueEmpty(queueEmpty),
    .headIdx(headIdx), .waitMask(waitMask), .strobe(strobe),
    .pushIdx(pushIdx), .grant(grant), .overflowErr(overflowErr)
  );

  sem_dpath #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .initCount(initCount), .strobe(strobe),
    .pushIdx(pushIdx), .countZero(countZero), .countFull(countFull),
    .queueEmpty(queueEmpty), .headIdx(headIdx), .waitMask(waitMask)
  );
endmodule

// File: tb/sem_top_tb.sv
module sem_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] initCount = '0;
  logic [3:0] reqValid = '0;
  logic [3:0] reqOp = '0;
  logic [3:0] grant;
  logic       overflowErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] g;
    logic       e;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  sem_top #(.NUM_PORTS(4), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .initCount(initCount),
    .reqValid(reqValid), .reqOp(reqOp), .grant(grant), .overflowErr(overflowErr)
  );

  // Driver: apply one cycle of requests and queue the expected outputs.
  task automatic step(input logic [3:0] rv, input logic [3:0] op,
                      input logic [3:0] eg, input logic ee, input string tag);
    @(negedge clk);
    reqValid = rv;
    reqOp    = op;
    expQ.push_back('{g: eg, e: ee, tag: tag});
  endtask

  task automatic doReset(input logic [3:0] init);
    @(negedge clk);
    rst_n = 1'b0; initCount = init; reqValid = '0; reqOp = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare outputs mid-cycle against the queued expectation.
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      compared++;
      if (grant !== it.g || overflowErr !== it.e) begin
        mismatched++;
        $display("FAIL %s: grant=%b err=%b expected grant=%b err=%b",
                 it.tag, grant, overflowErr, it.g, it.e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Ceiling 2
    doReset(4'd2);
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, "R1 idle after reset");
    step(4'b0001, 4'b0000, 4'b0001, 1'b0, "R2 acquire port0");
    step(4'b0010, 4'b0000, 4'b0010, 1'b0, "R2 acquire port1");
    step(4'b0100, 4'b0000, 4'b0000, 1'b0, "R3 port2 blocks");
    step(4'b1100, 4'b0000, 4'b0000, 1'b0, "R3 port3 blocks");
    step(4'b1100, 4'b0000, 4'b0000, 1'b0, "R3 waiters held");
    step(4'b1101, 4'b0001, 4'b0101, 1'b0, "R5 handoff to port2");
    step(4'b1010, 4'b0010, 4'b1010, 1'b0, "R6 handoff to port3 second");
    step(4'b0100, 4'b0100, 4'b0100, 1'b0, "R4 release no waiters");
    step(4'b1011, 4'b0000, 4'b1000, 1'b0, "R7 round robin picks port3");
    step(4'b0011, 4'b0000, 4'b0000, 1'b0, "R7 port0 next, blocks");
    step(4'b0011, 4'b0000, 4'b0000, 1'b0, "R7 port1 next, blocks");
    step(4'b1011, 4'b1000, 4'b1001, 1'b0, "R6 oldest waiter port0");
    step(4'b0011, 4'b0001, 4'b0011, 1'b0, "R6 then port1");
    step(4'b0010, 4'b0010, 4'b0010, 1'b0, "R4 release count to 1");
    step(4'b1000, 4'b1000, 4'b1000, 1'b0, "R4 release count to 2");
    step(4'b0100, 4'b0100, 4'b0100, 1'b1, "R8 release at ceiling flags");
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, "R8 error is a pulse");
    step(4'b0001, 4'b0000, 4'b0001, 1'b0, "R8 saturated count token 1");
    step(4'b0010, 4'b0000, 4'b0010, 1'b0, "R8 saturated count token 2");
    step(4'b0100, 4'b0000, 4'b0000, 1'b0, "R9 no third token");
    step(4'b1100, 4'b1000, 4'b1100, 1'b0, "R5 handoff count stays 0");
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, "R9 quiet");
    // Ceiling 0
    doReset(4'd0);
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, "R1 idle after reset ceiling 0");
    step(4'b0010, 4'b0000, 4'b0000, 1'b0, "R10 acquire blocks at ceiling 0");
    step(4'b0011, 4'b0001, 4'b0011, 1'b0, "R10 release hands token");
    step(4'b0100, 4'b0100, 4'b0100, 1'b1, "R8 release beyond ceiling 0");
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, "R10 quiet");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule